// File: doc/BRIEF.md
# Raster Timing Generator with Offset-Coded Boundaries

This block produces the horizontal and vertical timing of a raster display. Two position counters, one advancing on each pixel-clock enable and one on each line wrap, are compared against six boundary points per axis. The points are sync end, border start, display start, display end, border end and total. From these comparisons the block drives horizontal sync, vertical sync, a display window, a border window and a vertical window for a hardware cursor overlay. A control word carries a global video enable and a separate sync polarity inversion for each axis.

Software programs each boundary as a cumulative count. Every horizontal register holds its point minus a fixed pipeline offset, and low bits are ignored for alignment. The generator adds each offset back before comparing. Each vertical register holds its line count minus one. All writes land in shadow copies. A two-state machine tracks whether the shadow differs from the active set. In state SHD_CLEAN a valid write moves it to SHD_PENDING. In SHD_PENDING the last pixel of a frame copies the shadow into the active set, and the machine returns to SHD_CLEAN unless a write arrives in that same cycle, in which case it stays in SHD_PENDING. The new set therefore takes effect exactly at the first pixel of the next frame, where vertical sync begins, and no frame is torn.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every active register and both counters are zero, so h_pos=0, v_pos=0, hsync=1, vsync=1, disp_en=0, border_en=0 and cursor_vwin=0.
- R2: h_pos advances only on cycles with pix_en=1. The line length is HT pixel enables, and h_pos returns to 0 after HT-1. v_pos advances when h_pos wraps and returns to 0 after VT-1.
- R3: Horizontal registers sit at addresses 0..5 in the order sync end, border start, display start, display end, border end, total. The point each one describes is its value plus 8, 12, 18, 18, 12 and 8 respectively. Bit 0 is ignored for addresses 0..4, and bits 1:0 are ignored for address 5 (HT).
- R4: Vertical registers sit at addresses 6..11 in the same order. The point each one describes is its value plus 1, and the point at address 11 is VT.
- R5: hsync is 1 while h_pos is below the horizontal sync end, XOR control bit 16. vsync is 1 while v_pos is below the vertical sync end, XOR control bit 18.
- R6: disp_en is 1 when control bit 12 is set, h_pos lies in [display start, display end) horizontally, and v_pos lies in the same window vertically.
- R7: border_en is 1 when control bit 12 is set, both positions lie in their [border start, border end) windows, and disp_en is 0.
- R8: With control bit 12 clear, disp_en and border_en stay 0 while both syncs and both counters keep running.
- R9: cursor_vwin is 1 when v_pos lies in [cursor top, cursor bottom), with cursor top at address 13 and cursor bottom at address 14. It does not depend on the enable bit.
- R10: Writes reach only the shadow set. The active set is replaced at the clock edge ending a frame, meaning pix_en=1 with h_pos=HT-1 and v_pos=VT-1. A write in that same cycle is applied at the end of the following frame.
- R11: A write to address 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0..14 valid) |
| wr_data | input | 20 | Write data; timing values use bits 11:0, control uses bits 12, 16 and 18 |
| h_pos | output | 13 | Current pixel position in the line |
| v_pos | output | 13 | Current line in the frame |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| disp_en | output | 1 | Active display window |
| border_en | output | 1 | Border window outside the display area |
| cursor_vwin | output | 1 | Cursor vertical window |

## Verification
The assertions take for granted that the position counters are compared only against an active boundary set that changes at a frame edge. They also assume the line length fits the counter width, which holds for any 12-bit register value. Both assumptions rest on R10, and the bench never tries to bypass that rule. The stimulus keeps every programmed total at least one beyond the positions in use. Random configurations are built as growing cumulative points that are converted into register values, so each total stays well inside the counter range while the low alignment bits are randomised.

// File: rtl/raster_pkg.sv
package raster_pkg;
    parameter int RG_W    = 12;
    parameter int POS_W   = RG_W + 1;
    parameter int DATA_W  = 20;
    parameter int ADDR_W  = 4;
    parameter int NUM_BND = 6;

    localparam int BND_SYNC   = 0;
    localparam int BND_BSTART = 1;
    localparam int BND_DSTART = 2;
    localparam int BND_DEND   = 3;
    localparam int BND_BEND   = 4;
    localparam int BND_TOTAL  = 5;

    localparam int ADR_H0   = 0;
    localparam int ADR_V0   = ADR_H0 + NUM_BND;
    localparam int ADR_CTRL = ADR_V0 + NUM_BND;
    localparam int ADR_CTOP = ADR_CTRL + 1;
    localparam int ADR_CBOT = ADR_CTOP + 1;

    localparam int CTRL_EN_BIT   = 12;
    localparam int CTRL_HPOL_BIT = 16;
    localparam int CTRL_VPOL_BIT = 18;

    typedef logic [NUM_BND-1:0][RG_W-1:0] bnd_set_t;

    typedef struct packed {
        bnd_set_t        hb;
        bnd_set_t        vb;
        logic            en;
        logic            hpol;
        logic            vpol;
        logic [RG_W-1:0] cur_top;
        logic [RG_W-1:0] cur_bot;
    } raster_cfg_t;

    typedef enum logic {SHD_CLEAN, SHD_PENDING} shadow_st_t;

    // Fixed pipeline offset added back to each horizontal boundary.
    function automatic int h_offset(input int idx);
        case (idx)
            BND_SYNC:   return 8;
            BND_BSTART: return 12;
            BND_DSTART: return 18;
            BND_DEND:   return 18;
            BND_BEND:   return 12;
            default:    return 8;
        endcase
    endfunction

    // Total is aligned to 4, every other horizontal point to 2.
    function automatic logic [RG_W-1:0] h_align(input int idx, input logic [RG_W-1:0] v);
        if (idx == BND_TOTAL) return {v[RG_W-1:2], 2'b00};
        return {v[RG_W-1:1], 1'b0};
    endfunction
endpackage

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_end,
    output raster_cfg_t       active
);
    raster_cfg_t shadow;
    shadow_st_t  st, st_nxt;
    logic        wr_ok;
    logic        load;

    assign wr_ok = wr_en && (wr_addr <= ADDR_W'(ADR_CBOT));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_ok) begin
            for (int i = 0; i < NUM_BND; i++) begin
                if (wr_addr == ADDR_W'(ADR_H0 + i)) shadow.hb[i] <= wr_data[RG_W-1:0];
                if (wr_addr == ADDR_W'(ADR_V0 + i)) shadow.vb[i] <= wr_data[RG_W-1:0];
            end
            if (wr_addr == ADDR_W'(ADR_CTRL)) begin
                shadow.en   <= wr_data[CTRL_EN_BIT];
                shadow.hpol <= wr_data[CTRL_HPOL_BIT];
                shadow.vpol <= wr_data[CTRL_VPOL_BIT];
            end
            if (wr_addr == ADDR_W'(ADR_CTOP)) shadow.cur_top <= wr_data[RG_W-1:0];
            if (wr_addr == ADDR_W'(ADR_CBOT)) shadow.cur_bot <= wr_data[RG_W-1:0];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SHD_CLEAN;
        else        st <= st_nxt;
    end

    // Next state and outputs
    always_comb begin
        load   = 1'b0;
        st_nxt = st;
        unique case (st)
            SHD_CLEAN: begin
                if (wr_ok) st_nxt = SHD_PENDING;
            end
            SHD_PENDING: begin
                load = frame_end;
                if (frame_end && !wr_ok) st_nxt = SHD_CLEAN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    active <= '0;
        else if (load) active <= shadow;
    end
endmodule

// File: rtl/raster_axis.sv
module raster_axis
    import raster_pkg::*;
#(
    parameter bit HORIZ = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  bnd_set_t         bnd,
    output logic [POS_W-1:0] pos,
    output logic             at_end,
    output logic             in_sync,
    output logic             in_border,
    output logic             in_disp
);
    logic [NUM_BND-1:0][POS_W-1:0] edge_pos;

    for (genvar gi = 0; gi < NUM_BND; gi++) begin : g_edge
        if (HORIZ) begin : g_h
            assign edge_pos[gi] = POS_W'(h_align(gi, bnd[gi])) + POS_W'(h_offset(gi));
        end else begin : g_v
            assign edge_pos[gi] = POS_W'(bnd[gi]) + POS_W'(1);
        end
    end

    assign at_end = (pos == edge_pos[BND_TOTAL] - POS_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (step) pos <= at_end ? '0 : pos + POS_W'(1);
    end

    assign in_sync   = pos < edge_pos[BND_SYNC];
    assign in_border = (pos >= edge_pos[BND_BSTART]) && (pos < edge_pos[BND_BEND]);
    assign in_disp   = (pos >= edge_pos[BND_DSTART]) && (pos < edge_pos[BND_DEND]);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [POS_W-1:0]  h_pos,
    output logic [POS_W-1:0]  v_pos,
    output logic              hsync,
    output logic              vsync,
    output logic              disp_en,
    output logic              border_en,
    output logic              cursor_vwin
);
    raster_cfg_t active;
    logic h_end, v_end, frame_end, v_step;
    logic h_sync, h_bord, h_disp;
    logic v_sync, v_bord, v_disp;

    assign v_step    = pix_en && h_end;
    assign frame_end = v_step && v_end;

    raster_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .frame_end (frame_end),
        .active    (active)
    );

    raster_axis #(.HORIZ(1'b1)) u_hax (
        .clk(clk), .rst_n(rst_n), .step(pix_en), .bnd(active.hb),
        .pos(h_pos), .at_end(h_end), .in_sync(h_sync),
        .in_border(h_bord), .in_disp(h_disp)
    );

    raster_axis #(.HORIZ(1'b0)) u_vax (
        .clk(clk), .rst_n(rst_n), .step(v_step), .bnd(active.vb),
        .pos(v_pos), .at_end(v_end), .in_sync(v_sync),
        .in_border(v_bord), .in_disp(v_disp)
    );

    always_comb begin
        hsync       = h_sync ^ active.hpol;
        vsync       = v_sync ^ active.vpol;
        disp_en     = active.en && h_disp && v_disp;
        border_en   = active.en && h_bord && v_bord && !(h_disp && v_disp);
        cursor_vwin = (v_pos >= POS_W'(active.cur_top)) && (v_pos < POS_W'(active.cur_bot));
    end
endmodule

// File: rtl/raster_checker.sv
module raster_checker
    import raster_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pix_en,
    input logic             h_end,
    input logic             frame_end,
    input logic [POS_W-1:0] h_pos,
    input logic [POS_W-1:0] v_pos,
    input logic             disp_en,
    input logic             border_en,
    input raster_cfg_t      act
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(h_pos) && $stable(v_pos)));

    assert_vstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_en && h_end) |=> $stable(v_pos));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (h_pos == '0 && v_pos == '0));

    assert_hbound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        h_pos < (POS_W'({act.hb[BND_TOTAL][RG_W-1:2], 2'b00}) + POS_W'(8)));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_en && border_en));

    assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !act.en |-> (!disp_en && !border_en));

    assert_defer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(act));
endmodule

bind raster_timing_gen raster_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_en    (pix_en),
    .h_end     (h_end),
    .frame_end (frame_end),
    .h_pos     (h_pos),
    .v_pos     (v_pos),
    .disp_en   (disp_en),
    .border_en (border_en),
    .act       (active)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic [12:0] h_pos, v_pos;
    logic        hsync, vsync, disp_en, border_en, cursor_vwin;

    int checks = 0;
    int fails  = 0;
    bit run_chk = 1'b0;
    bit pe_full = 1'b0;
    string ph = "";

    always #10 clk = ~clk;

    raster_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .h_pos(h_pos), .v_pos(v_pos),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .border_en(border_en), .cursor_vwin(cursor_vwin)
    );

    // Reference model state
    int  m_sh[15];
    int  m_act[15];
    bit  m_dirty;
    int  m_h, m_v;
    int  t_ht, t_vt;
    bit  t_hend, t_fe, t_wok;

    function automatic int hoff(int i);
        int o[6] = '{8, 12, 18, 18, 12, 8};
        return o[i];
    endfunction

    function automatic int hrec(int i);
        int v = m_act[i] & 'hFFF;
        v = (i == 5) ? (v & ~3) : (v & ~1);
        return v + hoff(i);
    endfunction

    function automatic int vrec(int i);
        return (m_act[6 + i] & 'hFFF) + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_h = 0; m_v = 0; m_dirty = 0;
            for (int i = 0; i < 15; i++) begin m_sh[i] = 0; m_act[i] = 0; end
        end else begin
            t_ht   = hrec(5);
            t_vt   = vrec(5);
            t_hend = (m_h == t_ht - 1);
            t_fe   = pix_en && t_hend && (m_v == t_vt - 1);
            t_wok  = wr_en && (int'(wr_addr) <= 14);
            if (pix_en) begin
                if (t_hend) begin
                    m_h = 0;
                    m_v = (m_v == t_vt - 1) ? 0 : m_v + 1;
                end else m_h = m_h + 1;
            end
            if (t_fe && m_dirty) m_act = m_sh;
            if (t_fe) m_dirty = t_wok;
            else if (t_wok) m_dirty = 1;
            if (t_wok) m_sh[wr_addr] = (wr_addr == 12) ? int'(wr_data) : int'(wr_data) & 'hFFF;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string tag(string base);
        return (ph == "") ? base : {base, " ", ph};
    endfunction

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (run_chk && rst_n) begin
            int en, hd, vd, hb, vb, e_disp;
            en = (m_act[12] >> 12) & 1;
            hd = (m_h >= hrec(2) && m_h < hrec(3)) ? 1 : 0;
            vd = (m_v >= vrec(2) && m_v < vrec(3)) ? 1 : 0;
            hb = (m_h >= hrec(1) && m_h < hrec(4)) ? 1 : 0;
            vb = (m_v >= vrec(1) && m_v < vrec(4)) ? 1 : 0;
            e_disp = en & hd & vd;
            chk(tag("R2 R3"), "h_pos", int'(h_pos), m_h);
            chk(tag("R2 R4"), "v_pos", int'(v_pos), m_v);
            chk(tag("R5"), "hsync", int'(hsync), ((m_h < hrec(0)) ? 1 : 0) ^ ((m_act[12] >> 16) & 1));
            chk(tag("R5"), "vsync", int'(vsync), ((m_v < vrec(0)) ? 1 : 0) ^ ((m_act[12] >> 18) & 1));
            chk(tag("R6"), "disp_en", int'(disp_en), e_disp);
            chk(tag("R7"), "border_en", int'(border_en), en & hb & vb & (e_disp ^ 1));
            chk(tag("R9"), "cursor_vwin", int'(cursor_vwin),
                (m_v >= (m_act[13] & 'hFFF) && m_v < (m_act[14] & 'hFFF)) ? 1 : 0);
        end
    end

    // Pixel enable: random about 3 in 4, or continuous
    always @(negedge clk) begin
        if (run_chk) pix_en <= pe_full ? 1'b1 : ($urandom_range(0, 3) != 0);
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 20'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog_random();
        int c[6];
        int vc[6];
        c[0] = 8 + $urandom_range(0, 7);
        c[1] = ((c[0] > 12) ? c[0] : 12) + $urandom_range(0, 5);
        c[2] = ((c[1] > 18) ? c[1] : 18) + $urandom_range(0, 7);
        c[3] = c[2] + 2 + $urandom_range(0, 19);
        c[4] = c[3] + $urandom_range(0, 5);
        c[5] = c[4] + 4 + $urandom_range(0, 7);
        for (int i = 0; i < 6; i++)
            wr(i, (c[i] - hoff(i)) | $urandom_range(0, (i == 5) ? 3 : 1));
        vc[0] = 1 + $urandom_range(0, 1);
        vc[1] = vc[0] + $urandom_range(0, 1);
        vc[2] = vc[1] + $urandom_range(0, 2);
        vc[3] = vc[2] + 1 + $urandom_range(0, 3);
        vc[4] = vc[3] + $urandom_range(0, 1);
        vc[5] = vc[4] + 1 + $urandom_range(0, 1);
        for (int i = 0; i < 6; i++) wr(6 + i, vc[i] - 1);
        wr(12, ($urandom_range(0, 3) != 0 ? (1 << 12) : 0) |
               ($urandom_range(0, 1) << 16) | ($urandom_range(0, 1) << 18));
        wr(13, $urandom_range(0, vc[5]));
        wr(14, $urandom_range(0, vc[5] + 2));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state, no pixel enables yet
        chk("R1", "h_pos", int'(h_pos), 0);
        chk("R1", "v_pos", int'(v_pos), 0);
        chk("R1", "hsync", int'(hsync), 1);
        chk("R1", "vsync", int'(vsync), 1);
        chk("R1", "disp_en", int'(disp_en), 0);
        chk("R1", "border_en", int'(border_en), 0);
        chk("R1", "cursor_vwin", int'(cursor_vwin), 0);
        run_chk = 1'b1;

        // R3: alignment bits set, continuous pixels
        pe_full = 1'b1;
        ph = "R3";
        wr(0, 1); wr(1, 3); wr(2, 5); wr(3, 21); wr(4, 27); wr(5, 47);
        wr(6, 0); wr(7, 1); wr(8, 2); wr(9, 5); wr(10, 6); wr(11, 7);
        wr(12, (1 << 12) | (1 << 16)); wr(13, 2); wr(14, 5);
        repeat (2000) @(negedge clk);

        // R10: rewrite mid-frame, old values stay until the frame edge
        ph = "R10";
        pe_full = 1'b0;
        wr(3, 31); wr(9, 4); wr(12, (1 << 12) | (1 << 18));
        repeat (2500) @(negedge clk);

        // R8: blank the display, syncs continue
        ph = "R8";
        wr(12, 0);
        repeat (2500) @(negedge clk);

        // R11: write to the unused address
        ph = "R11";
        wr(15, 20'hFFFFF);
        repeat (2500) @(negedge clk);

        ph = "";
        for (int k = 0; k < 12; k++) begin
            pe_full = (k % 4 == 3);
            prog_random();
            repeat (3600) @(negedge clk);
        end

        run_chk = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule